// File: doc/BRIEF.md
# Video Line CRC Checker

This block watches a stream of 20-bit descrambled video words. Each word carries a luma sample in bits 19:10 and a chroma sample in bits 9:0. The block finds the timing references that open and close the active part of each line. It keeps a separate running CRC for each of the two 10-bit channels, covering the active picture, the closing reference and the two line-number words after it. It then compares those CRCs with the two check words that follow.

A mismatch in either channel, or in either check word, raises a single error flag. The flag stays high until the closing reference of the next line marks a line boundary. Words are taken only when the valid strobe is high. When the enable is low, the checker is held idle and the flag is forced low.

Top module: `vlc_line_crc_chk`

## Requirements
- R1: After a synchronous active-high reset, `crc_err` is low.
- R2: Luma occupies `din[19:10]` and chroma occupies `din[9:0]`. Each channel has its own CRC and its own comparison.
- R3: A timing reference is four consecutive accepted words: 20'hFFFFF, 20'h00000, 20'h00000, then a status word. In the status word, `din[16]` (luma bit 6) is 1 for the end-of-line reference and 0 for the start reference.
- R4: Each channel CRC is an 18-bit register, cleared when a start reference's status word is accepted. For each accepted word from the first word after that status word through the second word after the end status word, the register takes the 10 channel bits, LSB first. For each bit d: f = d ^ c[0]; c = c >> 1; if f, then c ^= 18'h23000 (polynomial x^18+x^5+x^4+1).
- R5: The third and fourth accepted words after the end status word are the check words. Per channel, bits 8:0 are compared with CRC bits 8:0 and CRC bits 17:9 respectively. Bit 9 of each channel is not examined.
- R6: `crc_err` rises in the cycle after a check word that mismatches is accepted.
- R7: Once high, `crc_err` holds until the next end-of-line status word is accepted. It is low from the following cycle.
- R8: A word presented while `vld` is low has no effect on reference detection, the CRCs or `crc_err`.
- R9: While `en` is low, `crc_err` is low from the next cycle. The line sequence restarts and needs a new start reference before any check is made.
- R10: A mismatch in either channel of either check word sets `crc_err`.
- R11: An end reference that is not preceded, within the same enabled run, by a start reference causes no comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Checker enable |
| vld | input | 1 | Word valid strobe |
| din | input | 20 | Descrambled word, luma high half, chroma low half |
| crc_err | output | 1 | Sticky per-line CRC error flag |

## Verification
Lines with correct check words show that the two per-channel CRCs match the stated algorithm. A single flipped bit in the luma half or the chroma half of either check word separates the channels and the two check-word halves. Flipping only bit 9 of each channel shows which bits take part in the comparison. Idle cycles carrying reference-like data, enable drops in the middle of a line, and end references with no start reference show that the flag is sticky and cleared only at line boundaries, and that only proper sequences arm a check.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
    localparam int CH_W    = 10;
    localparam int N_CH    = 2;
    localparam int WORD_W  = CH_W * N_CH;
    localparam int CRC_W   = 18;
    localparam int CHK_W   = CRC_W / 2;
    localparam int XYZ_BIT = CH_W + 6;
    localparam logic [CRC_W-1:0] CRC_MASK = 18'h23000;

    typedef enum logic [2:0] {
        ST_BLANK,
        ST_ACTIVE,
        ST_LN0,
        ST_LN1,
        ST_CK0,
        ST_CK1
    } line_st_e;

    typedef struct packed {
        logic sav;
        logic eav;
    } trs_hit_t;

    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] c_in,
        input logic [CH_W-1:0]  d
    );
        logic [CRC_W-1:0] c;
        logic             f;
        c = c_in;
        for (int i = 0; i < CH_W; i++) begin
            f = d[i] ^ c[0];
            c = c >> 1;
            if (f) c = c ^ CRC_MASK;
        end
        return c;
    endfunction
endpackage

// File: rtl/vlc_trs_detect.sv
module vlc_trs_detect
    import vlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              vld,
    input  logic [WORD_W-1:0] din,
    output trs_hit_t          hit
);
    logic [WORD_W-1:0] h0, h1, h2;
    logic              pre_ok;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            h0 <= '0;
            h1 <= '0;
            h2 <= '0;
        end else if (vld) begin
            h0 <= din;
            h1 <= h0;
            h2 <= h1;
        end
    end

    always_comb begin
        pre_ok  = (h2 == {WORD_W{1'b1}}) && (h1 == '0) && (h0 == '0);
        hit.sav = en && vld && pre_ok && !din[XYZ_BIT];
        hit.eav = en && vld && pre_ok &&  din[XYZ_BIT];
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !vld) |=> ($stable(h0) || !$past(en))) else $error("hist moved"); // R8
endmodule

// File: rtl/vlc_line_ctrl.sv
module vlc_line_ctrl
    import vlc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     vld,
    input  trs_hit_t hit,
    output line_st_e st,
    output logic     acc,
    output logic     clr,
    output logic     chk_lo,
    output logic     chk_hi
);
    line_st_e st_nx;

    always_comb begin
        st_nx = st;
        if (!en) begin
            st_nx = ST_BLANK;
        end else if (vld) begin
            if (hit.sav) begin
                st_nx = ST_ACTIVE;
            end else if (hit.eav) begin
                st_nx = (st == ST_ACTIVE) ? ST_LN0 : ST_BLANK;
            end else begin
                case (st)
                    ST_LN0:  st_nx = ST_LN1;
                    ST_LN1:  st_nx = ST_CK0;
                    ST_CK0:  st_nx = ST_CK1;
                    ST_CK1:  st_nx = ST_BLANK;
                    default: st_nx = st;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_BLANK;
        else     st <= st_nx;
    end

    always_comb begin
        clr    = hit.sav;
        acc    = en && vld && !hit.sav &&
                 (st == ST_ACTIVE || st == ST_LN0 || st == ST_LN1);
        chk_lo = en && vld && (st == ST_CK0);
        chk_hi = en && vld && (st == ST_CK1);
    end

    AST_CK_DONE: assert property (@(posedge clk) disable iff (rst)
        (en && vld && st == ST_CK1 && !hit.sav) |=> (st == ST_BLANK)) else $error("ck1 exit"); // R5
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == ST_BLANK)) else $error("not idle"); // R9
    AST_EAV_NO_START: assert property (@(posedge clk) disable iff (rst)
        (hit.eav && st != ST_ACTIVE) |=> (st == ST_BLANK)) else $error("orphan eav"); // R11
endmodule

// File: rtl/vlc_crc_chan.sv
module vlc_crc_chan
    import vlc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            acc,
    input  logic            clr,
    input  logic [CH_W-1:0] ch,
    output logic            mis_lo,
    output logic            mis_hi
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= '0;
        else if (acc)   crc_q <= crc_step(crc_q, ch);
    end

    always_comb begin
        mis_lo = ch[CHK_W-1:0] != crc_q[CHK_W-1:0];
        mis_hi = ch[CHK_W-1:0] != crc_q[CRC_W-1:CHK_W];
    end

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!acc && !clr) |=> $stable(crc_q)) else $error("crc moved"); // R8
    AST_CRC_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_q == '0)) else $error("crc not cleared"); // R4
endmodule

// File: rtl/vlc_line_crc_chk.sv
module vlc_line_crc_chk
    import vlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              vld,
    input  logic [WORD_W-1:0] din,
    output logic              crc_err
);
    trs_hit_t        hit;
    line_st_e        st;
    logic            acc, clr, chk_lo, chk_hi;
    logic [N_CH-1:0] mis_lo, mis_hi;
    logic            bad;

    vlc_trs_detect u_det (
        .clk (clk), .rst (rst), .en (en), .vld (vld), .din (din), .hit (hit)
    );

    vlc_line_ctrl u_ctrl (
        .clk (clk), .rst (rst), .en (en), .vld (vld), .hit (hit), .st (st),
        .acc (acc), .clr (clr), .chk_lo (chk_lo), .chk_hi (chk_hi)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        vlc_crc_chan u_crc (
            .clk    (clk),
            .rst    (rst),
            .acc    (acc),
            .clr    (clr),
            .ch     (din[g*CH_W +: CH_W]),
            .mis_lo (mis_lo[g]),
            .mis_hi (mis_hi[g])
        );
    end

    assign bad = (chk_lo && |mis_lo) || (chk_hi && |mis_hi);

    always_ff @(posedge clk) begin
        if (rst || !en)   crc_err <= 1'b0;
        else if (hit.eav) crc_err <= 1'b0;
        else if (bad)     crc_err <= 1'b1;
    end

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> !crc_err) else $error("err with en low"); // R9
    AST_EAV_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hit.eav |=> !crc_err) else $error("no clear at eav"); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (crc_err && en && !hit.eav) |=> crc_err) else $error("err dropped"); // R7
    AST_RISE_AT_CHECK: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_err) |-> $past(vld && (st == ST_CK0 || st == ST_CK1))) else $error("rise off check"); // R6
endmodule

// File: tb/test_vlc_line_crc_chk.sv
module test_vlc_line_crc_chk;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b1;
    logic        vld = 1'b0;
    logic [19:0] din = '0;
    logic        crc_err;

    int n_run  = 0;
    int n_fail = 0;
    logic [17:0] b_l, b_c;

    always #10 clk = ~clk;

    vlc_line_crc_chk i_vlc_line_crc_chk (
        .clk (clk), .rst (rst), .en (en), .vld (vld), .din (din), .crc_err (crc_err)
    );

    function automatic logic [17:0] ref_crc(input logic [17:0] c_in, input logic [9:0] d);
        logic [17:0] c = c_in;
        for (int i = 0; i < 10; i++) begin
            logic f = d[i] ^ c[0];
            c = c >> 1;
            if (f) c = c ^ 18'h23000;
        end
        return c;
    endfunction

    function automatic logic [9:0] rnd_sample();
        return 10'(4 + ($urandom % 1016));
    endfunction

    function automatic logic [19:0] xyz(input bit e);
        logic [9:0] v = e ? 10'h240 : 10'h200;
        return {v, v};
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: crc_err=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic put(input logic [19:0] w);
        int gaps = $urandom % 3;
        for (int i = 0; i < gaps; i++) begin
            vld = 1'b0;
            din = 20'($urandom);
            @(negedge clk);
        end
        vld = 1'b1;
        din = w;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic put_acc(input logic [19:0] w);
        put(w);
        b_l = ref_crc(b_l, w[19:10]);
        b_c = ref_crc(b_c, w[9:0]);
    endtask

    // cor: 0 none, 1 luma ck0, 2 chroma ck1, 3 bit9 flips only, 4 luma ck1, 5 chroma ck0
    task automatic line(input int n, input int cor);
        logic [19:0] ck0, ck1;
        bit exp;
        put(20'hFFFFF); put(20'h0); put(20'h0); put(xyz(0));
        b_l = '0; b_c = '0;
        for (int i = 0; i < n; i++) put_acc({rnd_sample(), rnd_sample()});
        put_acc(20'hFFFFF); put_acc(20'h0); put_acc(20'h0); put_acc(xyz(1));
        chk(crc_err, 1'b0, "R7 clear at end ref");
        put_acc({rnd_sample(), rnd_sample()});
        put_acc({rnd_sample(), rnd_sample()});
        ck0 = {~b_l[8], b_l[8:0], ~b_c[8], b_c[8:0]};
        ck1 = {~b_l[17], b_l[17:9], ~b_c[17], b_c[17:9]};
        case (cor)
            1: ck0 ^= 20'(1) << (10 + $urandom % 9);
            2: ck1 ^= 20'(1) << ($urandom % 9);
            3: begin ck0 ^= 20'h80200; ck1 ^= 20'h80200; end
            4: ck1 ^= 20'(1) << (10 + $urandom % 9);
            5: ck0 ^= 20'(1) << ($urandom % 9);
            default: ;
        endcase
        exp = (cor != 0 && cor != 3);
        put(ck0);
        chk(crc_err, (cor == 1 || cor == 5), "R6 after first check word");
        put(ck1);
        if (cor == 2)      chk(crc_err, exp, "R2 chroma channel");
        else if (cor == 3) chk(crc_err, exp, "R5 bit 9 ignored");
        else if (cor == 0) chk(crc_err, exp, "R4 R3 good line");
        else               chk(crc_err, exp, "R10 mismatch");
        for (int i = 0; i < 3; i++) put({rnd_sample(), rnd_sample()});
        chk(crc_err, exp, "R7 sticky in blanking");
    endtask

    task automatic idle_fake_eav();
        logic [19:0] seq [4];
        seq[0] = 20'hFFFFF; seq[1] = 20'h0; seq[2] = 20'h0; seq[3] = xyz(1);
        for (int i = 0; i < 4; i++) begin
            vld = 1'b0; din = seq[i];
            @(negedge clk);
        end
    endtask

    task automatic orphan_tail();
        for (int i = 0; i < 4; i++) put({rnd_sample(), rnd_sample()});
        put(20'hFFFFF); put(20'h0); put(20'h0); put(xyz(1));
        put(20'h12345); put(20'h54321); put(20'h0ABCD); put(20'h3C3C3);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: crc_err=%0b expected completion", crc_err);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        b_l = '0; b_c = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(crc_err, 1'b0, "R1 reset");

        line(8, 0);
        line(6, 1);
        line(5, 0);
        line(7, 2);
        line(4, 3);
        line(9, 4);
        line(3, 5);

        idle_fake_eav();
        chk(crc_err, 1'b1, "R8 invalid words ignored");

        en = 1'b0;
        @(negedge clk);
        chk(crc_err, 1'b0, "R9 enable low");
        en = 1'b1;
        orphan_tail();
        chk(crc_err, 1'b0, "R11 end ref without start");

        put(20'hFFFFF); put(20'h0); put(20'h0); put(xyz(0));
        put({rnd_sample(), rnd_sample()});
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        orphan_tail();
        chk(crc_err, 1'b0, "R9 restart after enable drop");

        for (int k = 0; k < 25; k++) line(2 + $urandom % 20, $urandom % 6);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule